// File: doc/BRIEF.md
# Dual-Clock Sample Elastic Buffer with Programmable Pointer Alignment

This block moves a wide parallel sample from an input-rate clock into a separate output-rate clock. Each sample holds two 16-bit channels and a one-bit phase marker, and all 33 bits are captured together. Storage is a four-slot register file. A write pointer in the input domain and a read pointer in the output domain each step one slot on every edge of their own clock. There are no full or empty flags and the pointers never stall. The margin between the two pointers is set only by an alignment event.

The alignment event comes from one of several candidate signals, chosen by a 3-bit code. When the event fires, the write pointer restarts at slot 0. A toggle carries the event into the output domain through a two-flop synchronizer. On arrival it forces the read pointer to slot 1, which puts the reader two slots behind the writer. The write clock is either the primary input clock or an alternate data-rate clock. A bypass bit sends the input word straight to the output register, which is clocked in the output domain.

Top module: `ififo_top`

## Requirements
- R1: While rst_n is low, the outputs and every slot are zero. After release, with equal clocks and no alignment event, each output edge k shows the sample captured at write edge k-2, because the reset offsets are write slot 0 and read slot 2.
- R2: The two channels and the phase marker of a sample travel together and come out on the same output edge.
- R3: wr_clk_sel=0 writes on clk_pri and wr_clk_sel=1 writes on clk_alt. A missing edge on the clock that is not selected has no effect on the output.
- R4: Alignment codes: 1 = rising edge of tx_en, 2 = rising edge of in_phase, 3 = rising edge of qual_flag, 4 = rising edge of in_b[15], 5 = one-shot on a rising edge of in_a[15], 6 = rising edge of cfg_wr. All are sampled on the write clock.
- R5: On an event edge, the sample presented at that edge goes into slot 0 and the write pointer continues from slot 1.
- R6: The event reaches the read domain through a toggle and a two-flop synchronizer. On arrival the read pointer is forced to slot 1, so a lagging write pointer is realigned to a latency of two output edges when the clocks are equal.
- R7: Code 5 fires only while armed. A pulse on cfg_wr arms it, and the first qualifying edge disarms it, so later edges are ignored until the next cfg_wr. Under code 5, cfg_wr on its own does not realign.
- R8: Codes 0 and 7 never realign. Under any code, activity on the sources that are not selected does not realign.
- R9: With cfg_bypass=1, the output register loads the input word directly, one output edge after it is presented. The slots and pointers keep running, so clearing bypass restores the two-edge latency with no new event.
- R10: Both pointers wrap from slot 3 to slot 0 and advance on every edge of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary write-side clock |
| clk_alt | input | 1 | Alternate data-rate write-side clock |
| wr_clk_sel | input | 1 | Write clock select: 0 primary, 1 alternate (static) |
| clk_rd | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | 1 routes the input word straight to the output register |
| cfg_sync_sel | input | 3 | Alignment source code |
| cfg_wr | input | 1 | Configuration write strobe (arms one-shot, source for code 6) |
| tx_en | input | 1 | Transmit-enable alignment source |
| qual_flag | input | 1 | Qualifier alignment source |
| in_a | input | 16 | Channel A sample |
| in_b | input | 16 | Channel B sample |
| in_phase | input | 1 | Phase marker stored with the sample |
| out_a | output | 16 | Channel A output |
| out_b | output | 16 | Channel B output |
| out_phase | output | 1 | Phase marker output |

## Verification
Before each source is triggered, the bench knocks the write pointer one slot behind by removing a single alternate-clock edge. This makes a correct realignment visible as a return to exactly two edges of latency. A design that forces the wrong slot, skips the synchronizer delay, or decodes the wrong source keeps a one-edge latency and fails the comparison. The one-shot is fired a second time to catch a missing disarm, and cfg_wr is pulsed under code 5 to catch a write that realigns when it should only re-arm. Bypass entry and exit are checked for a one-edge path and for an instant return to the buffered latency, which catches pointers that stop while bypassed.

// File: rtl/ififo_pkg.sv
package ififo_pkg;

  typedef enum logic [2:0] {
    SYNC_OFF       = 3'd0,
    SYNC_TXEN      = 3'd1,
    SYNC_PHASE     = 3'd2,
    SYNC_QUAL      = 3'd3,
    SYNC_BMSB      = 3'd4,
    SYNC_AMSB_ONCE = 3'd5,
    SYNC_REGWR     = 3'd6,
    SYNC_NEVER     = 3'd7
  } sync_src_e;

  localparam int SRC_CNT = 6;

endpackage

// File: rtl/ififo_rst_sync.sv
module ififo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ififo_ptr_ring.sv
module ififo_ptr_ring #(
  parameter int DEPTH = 4,
  parameter int INIT  = 0,
  parameter int ALIGN = 0,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_i,
  output logic [PW-1:0] addr_o
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic [PW-1:0] addr;

  always_comb begin
    addr  = align_i ? PW'(ALIGN) : ptr_q;
    ptr_d = (addr == PW'(DEPTH - 1)) ? '0 : addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PW'(INIT);
    else        ptr_q <= ptr_d;
  end

  assign addr_o = addr;

  AST_PTR_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !align_i |=> ptr_q == PW'((int'($past(ptr_q)) + 1) % DEPTH)); // R10

  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    align_i |=> ptr_q == PW'((ALIGN + 1) % DEPTH)); // R6

endmodule

// File: rtl/ififo_sync_sel.sv
module ififo_sync_sel
  import ififo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       cfg_wr,
  input  logic       tx_en,
  input  logic       phase,
  input  logic       qual,
  input  logic       b_msb,
  input  logic       a_msb,
  output logic       sync_o
);

  sync_src_e          sel_e;
  logic [SRC_CNT-1:0] raw;
  logic [SRC_CNT-1:0] prev_q;
  logic [SRC_CNT-1:0] rise;
  logic               armed_q;
  logic               armed_d;
  logic               fire;

  always_comb begin
    sel_e = sync_src_e'(sel_i);
    raw   = {cfg_wr, a_msb, b_msb, qual, phase, tx_en};
    rise  = raw & ~prev_q;
    case (sel_e)
      SYNC_TXEN:      fire = rise[0];
      SYNC_PHASE:     fire = rise[1];
      SYNC_QUAL:      fire = rise[2];
      SYNC_BMSB:      fire = rise[3];
      SYNC_AMSB_ONCE: fire = rise[4] & armed_q;
      SYNC_REGWR:     fire = rise[5];
      default:        fire = 1'b0;
    endcase
    if (cfg_wr)                             armed_d = 1'b1;
    else if (sel_e == SYNC_AMSB_ONCE && fire) armed_d = 1'b0;
    else                                    armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= raw;
      armed_q <= armed_d;
    end
  end

  assign sync_o = fire;

  AST_SYNC_OFF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd0 || sel_i == 3'd7) |-> !sync_o); // R8

  AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'd5 && sync_o && !cfg_wr) |=> !(sel_i == 3'd5 && sync_o && !cfg_wr && !$past(cfg_wr))); // R7

endmodule

// File: rtl/ififo_pulse_xfer.sv
module ififo_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic pulse_i,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse_o
);

  logic            tog_q;
  logic [STAGES:0] chain_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)   tog_q <= 1'b0;
    else if (pulse_i) tog_q <= ~tog_q;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain_q <= '0;
    else            chain_q <= {chain_q[STAGES-1:0], tog_q};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/ififo_top.sv
module ififo_top #(
  parameter int CH_W        = 16,
  parameter int DEPTH       = 4,
  parameter int WR_ALIGN    = 0,
  parameter int RD_INIT     = 2,
  parameter int RD_ALIGN    = 1,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = 2 * CH_W + 1,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic            clk_pri,
  input  logic            clk_alt,
  input  logic            wr_clk_sel,
  input  logic            clk_rd,
  input  logic            rst_n,
  input  logic            cfg_bypass,
  input  logic [2:0]      cfg_sync_sel,
  input  logic            cfg_wr,
  input  logic            tx_en,
  input  logic            qual_flag,
  input  logic [CH_W-1:0] in_a,
  input  logic [CH_W-1:0] in_b,
  input  logic            in_phase,
  output logic [CH_W-1:0] out_a,
  output logic [CH_W-1:0] out_b,
  output logic            out_phase
);

  logic              wclk;
  logic              wr_rst_n;
  logic              rd_rst_n;
  logic              wr_sync;
  logic              rd_sync;
  logic [PW-1:0]     wr_addr;
  logic [PW-1:0]     rd_addr;
  logic [DEPTH-1:0]  wr_en;
  logic [WORD_W-1:0] in_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] out_q;
  logic [WORD_W-1:0] out_d;
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign wclk    = wr_clk_sel ? clk_alt : clk_pri;
  assign in_word = {in_phase, in_b, in_a};

  ififo_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk(wclk), .rst_n(rst_n), .rst_n_sync(wr_rst_n));

  ififo_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk(clk_rd), .rst_n(rst_n), .rst_n_sync(rd_rst_n));

  ififo_sync_sel u_sel (
    .clk(wclk), .rst_n(wr_rst_n), .sel_i(cfg_sync_sel), .cfg_wr(cfg_wr),
    .tx_en(tx_en), .phase(in_phase), .qual(qual_flag),
    .b_msb(in_b[CH_W-1]), .a_msb(in_a[CH_W-1]), .sync_o(wr_sync));

  ififo_pulse_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
    .src_clk(wclk), .src_rst_n(wr_rst_n), .pulse_i(wr_sync),
    .dst_clk(clk_rd), .dst_rst_n(rd_rst_n), .pulse_o(rd_sync));

  ififo_ptr_ring #(.DEPTH(DEPTH), .INIT(0), .ALIGN(WR_ALIGN)) u_wptr (
    .clk(wclk), .rst_n(wr_rst_n), .align_i(wr_sync), .addr_o(wr_addr));

  ififo_ptr_ring #(.DEPTH(DEPTH), .INIT(RD_INIT), .ALIGN(RD_ALIGN)) u_rptr (
    .clk(clk_rd), .rst_n(rd_rst_n), .align_i(rd_sync), .addr_o(rd_addr));

  always_comb begin
    for (int e = 0; e < DEPTH; e++) wr_en[e] = (wr_addr == PW'(e));
  end

  always_ff @(posedge wclk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) if (wr_en[e]) mem_q[e] <= in_word;
    end
  end

  always_comb begin
    rd_word = mem_q[rd_addr];
    out_d   = cfg_bypass ? in_word : rd_word;
  end

  always_ff @(posedge clk_rd or negedge rd_rst_n) begin
    if (!rd_rst_n) out_q <= '0;
    else           out_q <= out_d;
  end

  assign out_a     = out_q[CH_W-1:0];
  assign out_b     = out_q[2*CH_W-1:CH_W];
  assign out_phase = out_q[WORD_W-1];

  AST_BYPASS_DIRECT: assert property (@(posedge clk_rd) disable iff (!rd_rst_n)
    (cfg_bypass && $past(cfg_bypass) && $past(rd_rst_n)) |-> {out_phase, out_b, out_a} == $past(in_word)); // R9

endmodule

// File: tb/ififo_top_bench.sv
module ififo_top_bench;

  logic        clk = 1'b0;
  logic        alt_gate;
  logic        clk_alt;
  logic        wr_clk_sel;
  logic        rst_n;
  logic        cfg_bypass;
  logic [2:0]  cfg_sync_sel;
  logic        cfg_wr;
  logic        tx_en;
  logic        qual_flag;
  logic [15:0] in_a;
  logic [15:0] in_b;
  logic        in_phase;
  logic [15:0] out_a;
  logic [15:0] out_b;
  logic        out_phase;

  logic [32:0] cur, last, last2, last3;
  logic [32:0] out_w;
  logic        ph_pat;
  int          n;
  int          checks;
  int          errors;
  int          cyc;

  // rows: {sel[2:0], pulsed source[2:0] (7 = all), expect realigned}
  localparam logic [6:0] ROWS [9] = '{
    {3'd1, 3'd1, 1'b1}, {3'd2, 3'd2, 1'b1}, {3'd3, 3'd3, 1'b1},
    {3'd4, 3'd4, 1'b1}, {3'd5, 3'd5, 1'b1}, {3'd6, 3'd6, 1'b1},
    {3'd1, 3'd2, 1'b0}, {3'd0, 3'd7, 1'b0}, {3'd7, 3'd7, 1'b0}
  };

  always #2 clk = ~clk;
  assign clk_alt = clk & alt_gate;
  assign out_w   = {out_phase, out_b, out_a};

  ififo_top u_ififo_top (
    .clk_pri(clk), .clk_alt(clk_alt), .wr_clk_sel(wr_clk_sel), .clk_rd(clk),
    .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_sync_sel(cfg_sync_sel),
    .cfg_wr(cfg_wr), .tx_en(tx_en), .qual_flag(qual_flag),
    .in_a(in_a), .in_b(in_b), .in_phase(in_phase),
    .out_a(out_a), .out_b(out_b), .out_phase(out_phase));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  task automatic chk(input string req, input logic [32:0] got, input logic [32:0] exp, input logic want_eq);
    checks = checks + 1;
    if ((got == exp) != want_eq) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %s%h", req, got, want_eq ? "" : "different from ", exp);
    end
  endtask

  // pl bits: 0 tx_en, 1 phase, 2 qual, 3 b msb, 4 a msb, 5 cfg_wr
  task automatic step(input logic [5:0] pl, input logic gate);
    @(negedge clk);
    last3 = last2;
    last2 = last;
    last  = cur;
    n = n + 1;
    cur[14:0]  = 15'(n);
    cur[15]    = pl[4];
    cur[30:16] = ~15'(n);
    cur[31]    = pl[3];
    cur[32]    = pl[1] | (ph_pat & n[0]);
    {in_phase, in_b, in_a} = cur;
    tx_en     = pl[0];
    qual_flag = pl[2];
    cfg_wr    = pl[5];
    alt_gate  = gate;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(6'h00, 1'b1);
  endtask

  task automatic realign();
    cfg_sync_sel = 3'd6;
    step(6'h20, 1'b1);
    idle(8);
  endtask

  task automatic slip();
    step(6'h00, 1'b0);
    idle(4);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; n = 0; ph_pat = 1'b0;
    cur = '0; last = '0; last2 = '0; last3 = '0;
    alt_gate = 1'b1; wr_clk_sel = 1'b0; rst_n = 1'b0; cfg_bypass = 1'b0;
    cfg_sync_sel = 3'd0; cfg_wr = 1'b0; tx_en = 1'b0; qual_flag = 1'b0;
    in_a = '0; in_b = '0; in_phase = 1'b0;

    // R1: reset holds outputs at zero while data is applied
    idle(5);
    chk("R1 reset zero", out_w, 33'h0, 1'b1);
    rst_n = 1'b1;
    idle(10);
    for (int c = 0; c < 3; c++) begin
      step(6'h00, 1'b1);
      chk("R1 reset offsets give two-edge latency", out_w, last3, 1'b1);
    end

    // R4 / R5 / R6 / R8: table of sources, each after a one-slot slip
    wr_clk_sel = 1'b1;
    idle(2);
    for (int r = 0; r < 9; r++) begin
      realign();
      cfg_sync_sel = ROWS[r][6:4];
      idle(1);
      slip();
      step((ROWS[r][3:1] == 3'd7) ? 6'h3F : 6'(1 << (ROWS[r][3:1] - 1)), 1'b1);
      idle(8);
      for (int c = 0; c < 3; c++) begin
        step(6'h00, 1'b1);
        chk(ROWS[r][0] ? "R4 R5 R6 selected source realigns" : "R8 unselected or off code ignored",
            out_w, last3, ROWS[r][0]);
      end
    end

    // R7: one-shot fires once, re-armed only by cfg_wr
    realign();
    cfg_sync_sel = 3'd5;
    idle(1);
    slip();
    step(6'h10, 1'b1);
    idle(8);
    step(6'h00, 1'b1);
    chk("R7 first edge realigns", out_w, last3, 1'b1);
    slip();
    step(6'h10, 1'b1);
    idle(8);
    step(6'h00, 1'b1);
    chk("R7 second edge ignored", out_w, last3, 1'b0);
    step(6'h20, 1'b1);
    idle(8);
    step(6'h00, 1'b1);
    chk("R7 write only re-arms", out_w, last3, 1'b0);
    step(6'h10, 1'b1);
    idle(8);
    step(6'h00, 1'b1);
    chk("R7 re-armed edge realigns", out_w, last3, 1'b1);

    // R3: write clock select
    wr_clk_sel = 1'b0;
    idle(3);
    step(6'h00, 1'b0);
    idle(5);
    step(6'h00, 1'b1);
    chk("R3 unselected clock gap ignored", out_w, last3, 1'b1);
    wr_clk_sel = 1'b1;
    idle(3);
    slip();
    step(6'h00, 1'b1);
    chk("R3 selected alternate clock used", out_w, last3, 1'b0);

    // R2 / R9 / R10: phase pattern, bypass entry and exit
    realign();
    cfg_sync_sel = 3'd0;
    ph_pat = 1'b1;
    idle(6);
    for (int c = 0; c < 4; c++) begin
      step(6'h00, 1'b1);
      chk("R2 R10 word and phase travel together", out_w, last3, 1'b1);
    end
    cfg_bypass = 1'b1;
    idle(2);
    for (int c = 0; c < 3; c++) begin
      step(6'h00, 1'b1);
      chk("R9 bypass one-edge path", out_w, last, 1'b1);
    end
    cfg_bypass = 1'b0;
    idle(1);
    for (int c = 0; c < 3; c++) begin
      step(6'h00, 1'b1);
      chk("R9 buffered latency after bypass", out_w, last3, 1'b1);
    end

    // R1: asynchronous reset clears outputs at once
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears output", out_w, 33'h0, 1'b1);
    idle(2);
    report();
  end

endmodule